// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block turns one address-range maintenance request into a stream of per-line commands for a downstream cache port. A request carries an inclusive start address, an exclusive end address and an operation: invalidate, clean, or flush (clean followed by invalidate). The sequencer walks the range one cache line at a time. It presents each command as a line-aligned address together with either a clean strobe or an invalidate strobe, and it waits for the port's ready before moving on.

Invalidation treats the edge lines of a range with care. A line at either end that the range covers only in part may hold dirty bytes outside the range, so that line is cleaned before it is invalidated. Interior lines are only invalidated. A request that spans the whole address space is not walked line by line for invalidate or flush. It is handed to an external whole-cache walker through its own handshake. Every request, including an empty one, ends with a barrier request handshake followed by a one-cycle done pulse.

Top module: `cache_range_seq`

## Requirements
- R1: Every command has its low log2(LINE_BYTES) address bits at zero (5 bits for 32-byte lines). Exactly one of `cmd_clean` (clean) and `cmd_inval` (invalidate) is high while `cmd_valid` is high.
- R2: For invalidate (`req_op` = 2'b00) with a start that is not line-aligned, the first commands are a clean and then an invalidate of the line holding the start address.
- R3: For invalidate, every line from the first line boundary at or above start up to, but not including, end rounded down to a line boundary gets one invalidate only, in ascending address order.
- R4: For invalidate, if bytes below end remain after the interior lines, the line holding them gets a clean and then an invalidate.
- R5: For clean (`req_op` = 2'b01), start is rounded down to a line boundary and every line below end gets one clean only, in ascending order.
- R6: For flush (`req_op` = 2'b10, with 2'b11 treated the same), start is rounded down and every line below end gets a clean and then an invalidate.
- R7: A request with start zero and end all ones issues no line commands for invalidate or flush. Instead it holds `walk_valid` until `walk_ready`. A clean request with that span walks every line as in R5.
- R8: A command held while `cmd_ready` is low keeps its address and strobe unchanged. The invalidate of a line is never presented before that line's clean has been accepted.
- R9: A request with end not greater than start issues no line commands and no walker request, and still completes through the barrier and done.
- R10: After the last line command or walker handshake, exactly one barrier handshake (`bar_valid` held until `bar_ready`) takes place. `done` pulses for one cycle, in the cycle after that handshake.
- R11: `busy` rises in the cycle after a request is accepted and stays high through the `done` cycle. A `req_valid` seen while busy is ignored and does not change the command stream.
- R12: After reset, `busy`, `cmd_valid`, `walk_valid`, `bar_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Address one past the last byte of the range |
| req_op | input | 2 | 00 invalidate, 01 clean, 10 or 11 flush |
| busy | output | 1 | High from acceptance through done |
| cmd_valid | output | 1 | Line command present |
| cmd_ready | input | 1 | Cache port takes the command |
| cmd_addr | output | ADDR_W | Line-aligned command address |
| cmd_clean | output | 1 | Command is a clean |
| cmd_inval | output | 1 | Command is an invalidate |
| walk_valid | output | 1 | Whole-cache walk requested |
| walk_ready | input | 1 | Walker has finished |
| bar_valid | output | 1 | Barrier requested |
| bar_ready | input | 1 | Barrier has completed |
| done | output | 1 | One-cycle completion pulse |

## Verification
A small configuration with a 10-bit address space is swept over every operation. Start and end values step across aligned and misaligned positions, so the sweep covers ranges inside one line, ranges across one boundary, ranges across several lines and empty or reversed ranges. This separates the edge-line rule of invalidate from the plain loops of clean and flush. Ready patterns that stall on alternate or every third cycle expose commands that change or get reordered under back-pressure. Directed requests cover the full-span walker handoff for each operation, the top of the address space, the alternate flush code, and a request posted while busy.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;

    typedef enum logic [1:0] {
        OP_INV      = 2'b00,
        OP_CLEAN    = 2'b01,
        OP_FLUSH    = 2'b10,
        OP_FLUSH_B  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_CLEAN,
        ST_INVAL,
        ST_WALK,
        ST_BAR,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_INV_ONLY,
        ACT_CLEAN_ONLY,
        ACT_BOTH
    } act_e;

endpackage

// File: rtl/cmseq_line_math.sv
module cmseq_line_math #(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 5
) (
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    output logic [ADDR_W-1:0] start_floor_o,
    output logic              misaligned_o,
    output logic              full_span_o,
    output logic              empty_o
);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << LINE_SHIFT) - 1);

    always_comb begin
        start_floor_o = start_i & ~OFS_MASK;
        misaligned_o  = (start_i & OFS_MASK) != '0;
        full_span_o   = (start_i == '0) && (end_i == '1);
        empty_o       = end_i <= start_i;
    end
endmodule

// File: rtl/cmseq_planner.sv
module cmseq_planner
    import cmseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 5
) (
    input  op_e               op_i,
    input  logic [ADDR_W:0]   cur_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic              edge_pending_i,
    output act_e              act_o
);
    localparam int CUR_W = ADDR_W + 1;
    localparam logic [CUR_W-1:0] OFS_MASK = CUR_W'((1 << LINE_SHIFT) - 1);

    logic [CUR_W-1:0] end_ext;
    logic [CUR_W-1:0] end_floor;
    logic             below_end;
    logic             below_floor;

    always_comb begin
        end_ext     = {1'b0, end_i};
        end_floor   = end_ext & ~OFS_MASK;
        below_end   = cur_i < end_ext;
        below_floor = cur_i < end_floor;
        act_o       = ACT_NONE;
        unique case (op_i)
            OP_INV: begin
                if (edge_pending_i)   act_o = ACT_BOTH;
                else if (below_floor) act_o = ACT_INV_ONLY;
                else if (below_end)   act_o = ACT_BOTH;
                else                  act_o = ACT_NONE;
            end
            OP_CLEAN: act_o = below_end ? ACT_CLEAN_ONLY : ACT_NONE;
            default:  act_o = below_end ? ACT_BOTH : ACT_NONE;
        endcase
    end
endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
    import cmseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic [1:0]        req_op,
    output logic              busy,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_clean,
    output logic              cmd_inval,
    output logic              walk_valid,
    input  logic              walk_ready,
    output logic              bar_valid,
    input  logic              bar_ready,
    output logic              done
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int CUR_W      = ADDR_W + 1;
    localparam logic [CUR_W-1:0] LINE_STEP = CUR_W'(LINE_BYTES);

    typedef struct packed {
        state_e            st;
        logic [CUR_W-1:0]  cur;
        logic [ADDR_W-1:0] lim;
        op_e               op;
        logic              edge_pending;
        logic              inval_after;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [ADDR_W-1:0] start_floor;
    logic              start_misaligned;
    logic              full_span;
    logic              empty_range;
    act_e              act;
    op_e               req_op_e;

    assign req_op_e = op_e'(req_op);

    cmseq_line_math #(
        .ADDR_W    (ADDR_W),
        .LINE_SHIFT(LINE_SHIFT)
    ) math_i (
        .start_i      (req_start),
        .end_i        (req_end),
        .start_floor_o(start_floor),
        .misaligned_o (start_misaligned),
        .full_span_o  (full_span),
        .empty_o      (empty_range)
    );

    cmseq_planner #(
        .ADDR_W    (ADDR_W),
        .LINE_SHIFT(LINE_SHIFT)
    ) plan_i (
        .op_i          (r_q.op),
        .cur_i         (r_q.cur),
        .end_i         (r_q.lim),
        .edge_pending_i(r_q.edge_pending),
        .act_o         (act)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op           = req_op_e;
                    r_d.lim          = req_end;
                    r_d.cur          = {1'b0, start_floor};
                    r_d.edge_pending = (req_op_e == OP_INV) && start_misaligned;
                    r_d.inval_after  = 1'b0;
                    if (full_span && (req_op_e != OP_CLEAN)) r_d.st = ST_WALK;
                    else if (empty_range)                    r_d.st = ST_BAR;
                    else                                     r_d.st = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                r_d.edge_pending = 1'b0;
                r_d.inval_after  = (act == ACT_BOTH);
                unique case (act)
                    ACT_NONE:     r_d.st = ST_BAR;
                    ACT_INV_ONLY: r_d.st = ST_INVAL;
                    default:      r_d.st = ST_CLEAN;
                endcase
            end
            ST_CLEAN: begin
                if (cmd_ready) begin
                    if (r_q.inval_after) begin
                        r_d.st = ST_INVAL;
                    end else begin
                        r_d.cur = r_q.cur + LINE_STEP;
                        r_d.st  = ST_DECIDE;
                    end
                end
            end
            ST_INVAL: begin
                if (cmd_ready) begin
                    r_d.cur = r_q.cur + LINE_STEP;
                    r_d.st  = ST_DECIDE;
                end
            end
            ST_WALK: if (walk_ready) r_d.st = ST_BAR;
            ST_BAR:  if (bar_ready)  r_d.st = ST_DONE;
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st           <= ST_IDLE;
            r_q.cur          <= '0;
            r_q.lim          <= '0;
            r_q.op           <= OP_INV;
            r_q.edge_pending <= 1'b0;
            r_q.inval_after  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign cmd_valid  = (r_q.st == ST_CLEAN) || (r_q.st == ST_INVAL);
    assign cmd_clean  = (r_q.st == ST_CLEAN);
    assign cmd_inval  = (r_q.st == ST_INVAL);
    assign cmd_addr   = r_q.cur[ADDR_W-1:0];
    assign walk_valid = (r_q.st == ST_WALK);
    assign bar_valid  = (r_q.st == ST_BAR);
    assign done       = (r_q.st == ST_DONE);

    // R1
    cmd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr[LINE_SHIFT-1:0] == '0));

    // R1
    cmd_kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones({cmd_clean, cmd_inval}) == 1));

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_clean)));

    // R8
    clean_then_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clean && cmd_ready && r_q.inval_after) |=> (cmd_inval && $stable(cmd_addr)));

    // R10
    bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_valid && !bar_ready) |=> bar_valid);

    // R10
    done_after_bar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_valid && bar_ready) |=> done);

    // R11
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_valid && !walk_ready) |=> walk_valid);

    // R10
    bar_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bar_valid && (cmd_valid || walk_valid)));
endmodule

// File: tb/cache_range_seq_tb_top.sv
module cache_range_seq_tb_top;
    localparam int AW = 10;
    localparam int LB = 32;
    localparam int TOP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic [1:0]    req_op = 2'b00;
    logic          busy, cmd_valid, cmd_clean, cmd_inval, walk_valid, bar_valid, done;
    logic [AW-1:0] cmd_addr;
    logic          cmd_ready = 1'b0;
    logic          walk_ready = 1'b0;
    logic          bar_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    int r1_bad = 0;
    int r8_bad = 0;
    int cyc = 0;

    int exp_addr[$];
    bit exp_cln[$];

    always #2.5 clk = ~clk;

    cache_range_seq #(.ADDR_W(AW), .LINE_BYTES(LB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_start(req_start), .req_end(req_end), .req_op(req_op),
        .busy(busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_clean(cmd_clean), .cmd_inval(cmd_inval),
        .walk_valid(walk_valid), .walk_ready(walk_ready),
        .bar_valid(bar_valid), .bar_ready(bar_ready),
        .done(done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int a, input bit c);
        exp_addr.push_back(a);
        exp_cln.push_back(c);
    endtask

    // Expected line commands computed from R2..R7 and R9.
    task automatic build(input int s, input int e, input int op, output int walks);
        int p;
        exp_addr.delete();
        exp_cln.delete();
        walks = 0;
        if (s == 0 && e == TOP && op != 1) begin
            walks = 1;
        end else if (e <= s) begin
            walks = 0;
        end else if (op == 0) begin
            p = s;
            if (p % LB != 0) begin
                p = p - (p % LB);
                push(p, 1); push(p, 0);
                p = p + LB;
            end
            while (p < e - (e % LB)) begin
                push(p, 0);
                p = p + LB;
            end
            if (p < e) begin
                push(p, 1); push(p, 0);
            end
        end else begin
            p = s - (s % LB);
            while (p < e) begin
                push(p, 1);
                if (op != 1) push(p, 0);
                p = p + LB;
            end
        end
    endtask

    function automatic bit rdy(input int mode, input int n);
        case (mode)
            0: rdy = 1'b1;
            1: rdy = (n % 3) != 0;
            default: rdy = (n % 2) == 1;
        endcase
    endfunction

    task automatic run_req(input int s, input int e, input int op, input int mode,
                           input bit poke);
        int walks_exp, got, bad, bars, walks, dones, n, bar_at;
        bit seen_done, busy_gap, p_valid;
        int p_addr;
        bit p_cln;
        string tag;
        build(s, e, op, walks_exp);
        got = 0; bad = 0; bars = 0; walks = 0; dones = 0; n = 0; bar_at = -1;
        seen_done = 0; busy_gap = 0; p_valid = 0; p_addr = 0; p_cln = 0;
        @(negedge clk);
        req_start = AW'(s);
        req_end = AW'(e);
        req_op = 2'(op);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", int'(busy), 1);
        while (!seen_done && n < 2000) begin
            cmd_ready = rdy(mode, n);
            bar_ready = rdy(mode, n + 1);
            walk_ready = (n >= 4);
            if (poke && n == 1) begin
                req_start = AW'(0);
                req_end = AW'(TOP);
                req_op = 2'b01;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (!busy) busy_gap = 1;
            if (p_valid && (!cmd_valid || cmd_addr != AW'(p_addr) || cmd_clean != p_cln)) r8_bad++;
            p_valid = 0;
            if (cmd_valid) begin
                if (cmd_addr % LB != 0 || (cmd_clean == cmd_inval)) r1_bad++;
                if (!cmd_ready) begin
                    p_valid = 1; p_addr = int'(cmd_addr); p_cln = cmd_clean;
                end else begin
                    if (got >= exp_addr.size()) bad++;
                    else if (int'(cmd_addr) != exp_addr[got] || cmd_clean != exp_cln[got]) bad++;
                    if (bars != 0) bad++;
                    got++;
                end
            end
            if (walk_valid && walk_ready) walks++;
            if (bar_valid && bar_ready) begin
                bars++;
                bar_at = n;
            end
            if (done) begin
                dones++;
                seen_done = 1;
                chk(bar_at == n - 1, "R10", "done cycle after barrier", n - bar_at, 1);
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (s == 0 && e == TOP && op != 1) tag = "R7";
        else if (e <= s) tag = "R9";
        else if (op == 0) tag = "R2 R3 R4 invalidate";
        else if (op == 1) tag = "R5 clean";
        else tag = "R6 flush";
        chk(bad == 0 && got == exp_addr.size(), tag, "command stream count", got, exp_addr.size());
        chk(walks == walks_exp, "R7", "walker handshakes", walks, walks_exp);
        chk(bars == 1, "R10", "barrier handshakes", bars, 1);
        chk(!busy_gap, "R11", "busy held until done", int'(busy_gap), 0);
        chk(busy == 1'b0 && done == 1'b0, "R11", "idle after done", int'(busy), 0);
        cmd_ready = 1'b0;
        bar_ready = 1'b0;
        walk_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_valid && !walk_valid && !bar_valid && !done, "R12",
            "reset outputs low", int'({busy, cmd_valid, walk_valid, bar_valid, done}), 0);

        for (int op = 0; op < 3; op++) begin
            for (int s = 0; s < 96; s += 7) begin
                for (int e = 0; e < 128; e += 9) begin
                    run_req(s, e, op, (s + e) % 3, 1'b0);
                end
            end
        end
        // R7 full span per operation, R6 alternate flush code
        run_req(0, TOP, 0, 1, 1'b0);
        run_req(0, TOP, 2, 2, 1'b0);
        run_req(0, TOP, 3, 0, 1'b0);
        run_req(0, TOP, 1, 1, 1'b0);
        run_req(33, 130, 3, 2, 1'b0);
        // R4 near the top of the address space
        run_req(1000, 1023, 0, 1, 1'b0);
        run_req(990, 1023, 2, 0, 1'b0);
        // R9 aligned empty and reversed
        run_req(64, 64, 0, 0, 1'b0);
        run_req(100, 40, 2, 1, 1'b0);
        // R11 request posted while busy must be ignored
        run_req(5, 200, 0, 2, 1'b1);
        run_req(40, 140, 1, 1, 1'b1);

        chk(r1_bad == 0, "R1", "misaligned or ambiguous commands", r1_bad, 0);
        chk(r8_bad == 0, "R8", "commands changed while stalled", r8_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule